// File: doc/BRIEF.md
# DMA Page Register Address Generator

This block keeps two byte-wide page registers for each of four DMA channels: a low page and an optional high page. The host reaches them through byte-wide port accesses. A 3-bit port index goes through a fixed, non-sequential table that selects a channel. Indices that select no channel are refused and flagged.

On the address side, a consumer names a channel and supplies that channel's current 16-bit address, its direction bit, a position and a length. The block joins the page bytes and the current address into one physical base address. It then adds the position when counting up, or subtracts the position and the length when counting down. The address path is combinational from the stored pages and the address-side inputs. Port reads return data one clock after the access.

A parameter removes the high page bank entirely. When the bank is removed, its accesses are ignored and the upper address bits stay zero.

Top module: `dma_page_addrgen`

## Requirements
- R1: The index table works as follows: `acc_idx` 7 selects channel 0, 3 selects channel 1, 1 selects channel 2 and 2 selects channel 3. These are the only channel numbers used by `addr_ch`. An access to a mapped index never raises `acc_bad`.
- R2: A write (`acc_en`=1, `acc_wr`=1) to index 0, 4, 5 or 6 changes no page register. It sets `acc_bad` for exactly the following cycle.
- R3: A read (`acc_en`=1, `acc_wr`=0) of index 0, 4, 5 or 6 sets `acc_bad` in the following cycle and returns 8'hFF on `acc_rdata` in that cycle.
- R4: Each channel has a separate 8-bit low page (`acc_hi`=0) and an 8-bit high page (`acc_hi`=1). A read returns the stored byte on `acc_rdata` in the cycle after the access.
- R5: The physical base is {high page bits 6:0, low page, `cur_addr`}, 31 bits wide. Bit 7 of the high page is stored and can be read back, but it never reaches `phys_addr`.
- R6: With `dir_down`=0, `phys_addr` = base + `xfer_pos`, modulo 2^31.
- R7: With `dir_down`=1, `phys_addr` = base − `xfer_pos` − `xfer_len`, modulo 2^31.
- R8: With `HIGH_EN`=0, an access with `acc_hi`=1 writes nothing and raises no `acc_bad`. Its reads return 8'hFF, and `phys_addr[30:24]` is always 0.
- R9: Reset clears every page register to zero.
- R10: In a cycle after one with `acc_en`=0, `acc_bad` is 0 and `acc_rdata` is 8'h00. A write also leaves `acc_rdata` at 8'h00 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Page port access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_hi | input | 1 | 1 = high page bank, 0 = low page bank |
| acc_idx | input | 3 | Page port index |
| acc_wdata | input | 8 | Write byte |
| acc_rdata | output | 8 | Read byte, one cycle after the access |
| acc_bad | output | 1 | Invalid-access flag, one cycle after the access |
| addr_ch | input | 2 | Channel whose pages form the address |
| cur_addr | input | 16 | Channel's current address |
| dir_down | input | 1 | Channel direction: 1 = decrementing |
| xfer_pos | input | 16 | Position offset |
| xfer_len | input | 16 | Length subtracted when decrementing |
| phys_addr | output | 31 | Physical transfer address |

## Verification
The assertions check, on every cycle:
- the flag and the 8'hFF read value after an unmapped access;
- the quiet outputs after idle cycles;
- the absence of a flag on mapped indices;
- that a zero offset passes `cur_addr` straight into the low address bits in both directions;
- that the upper bits stay zero when the high bank is absent.

Only the bench's scenarios show the rest:
- that dropped writes really leave every page untouched;
- that bit 7 of the high page is kept but masked from the address;
- that the down-counting arithmetic borrows correctly across the page boundary;
- that the scrambled index order lands each byte in the right channel.

// File: rtl/dma_page_pkg.sv
package dma_page_pkg;

   localparam int unsigned NUM_CH = 4;
   localparam int unsigned CH_W   = 2;
   localparam int unsigned IDX_W  = 3;

   typedef struct packed {
      logic            hit;
      logic [CH_W-1:0] ch;
   } chan_sel_t;

   // Port index to channel table; the order is fixed by the system map.
   function automatic chan_sel_t map_port(input logic [IDX_W-1:0] idx);
      chan_sel_t s;
      s.hit = 1'b1;
      s.ch  = '0;
      case (idx)
         3'd1:    s.ch = 2'd2;
         3'd2:    s.ch = 2'd3;
         3'd3:    s.ch = 2'd1;
         3'd7:    s.ch = 2'd0;
         default: s.hit = 1'b0;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/dma_page_decode.sv
module dma_page_decode
   import dma_page_pkg::*;
#(
   parameter bit HIGH_EN = 1'b1
) (
   input  logic             acc_en,
   input  logic             acc_wr,
   input  logic             acc_hi,
   input  logic [IDX_W-1:0] acc_idx,
   output logic [CH_W-1:0]  sel_ch,
   output logic             wr_lo,
   output logic             wr_hi,
   output logic             rd_ok,
   output logic             rd_dead,
   output logic             flag
);
   chan_sel_t sel;
   logic      live;

   always_comb begin
      sel    = map_port(acc_idx);
      sel_ch = sel.ch;
      // An absent high bank swallows its accesses without a response.
      live    = !acc_hi || HIGH_EN;
      wr_lo   = acc_en &&  acc_wr && !acc_hi && sel.hit;
      wr_hi   = acc_en &&  acc_wr &&  acc_hi && sel.hit && HIGH_EN;
      rd_ok   = acc_en && !acc_wr && live && sel.hit;
      rd_dead = acc_en && !acc_wr && !(live && sel.hit);
      flag    = acc_en && live && !sel.hit;
   end
endmodule

// File: rtl/dma_page_bank.sv
module dma_page_bank #(
   parameter int unsigned NCH     = 4,
   parameter int unsigned W       = 8,
   parameter bit          PRESENT = 1'b1,
   localparam int unsigned SEL_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [SEL_W-1:0]      wr_ch,
   input  logic [W-1:0]          wr_data,
   input  logic [SEL_W-1:0]      rd_ch,
   output logic [W-1:0]          rd_byte,
   input  logic [SEL_W-1:0]      ad_ch,
   output logic [W-1:0]          ad_byte
);
   logic [NCH-1:0][W-1:0] pages;

   generate
      if (PRESENT) begin : g_regs
         for (genvar c = 0; c < NCH; c++) begin : g_ch
            always_ff @(posedge clk) begin
               if (!rst_n)
                  pages[c] <= '0;
               else if (wr_en && wr_ch == SEL_W'(c))
                  pages[c] <= wr_data;
            end
         end
      end else begin : g_none
         assign pages = '0;
      end
   endgenerate

   assign rd_byte = pages[rd_ch];
   assign ad_byte = pages[ad_ch];
endmodule

// File: rtl/dma_page_addr.sv
module dma_page_addr #(
   parameter int unsigned PAGE_W    = 8,
   parameter int unsigned HIGH_USED = 7,
   parameter int unsigned OFS_W     = 16,
   parameter int unsigned POS_W     = 16,
   localparam int unsigned PHYS_W   = HIGH_USED + PAGE_W + OFS_W
) (
   input  logic [PAGE_W-1:0] lo_page,
   input  logic [PAGE_W-1:0] hi_page,
   input  logic [OFS_W-1:0]  cur_addr,
   input  logic              dir_down,
   input  logic [POS_W-1:0]  xfer_pos,
   input  logic [POS_W-1:0]  xfer_len,
   output logic [PHYS_W-1:0] phys_addr
);
   logic [PHYS_W-1:0] base, pos_x, len_x;

   always_comb begin
      base  = {hi_page[HIGH_USED-1:0], lo_page, cur_addr};
      pos_x = {{(PHYS_W-POS_W){1'b0}}, xfer_pos};
      len_x = {{(PHYS_W-POS_W){1'b0}}, xfer_len};
      phys_addr = dir_down ? (base - pos_x - len_x) : (base + pos_x);
   end
endmodule

// File: rtl/dma_page_addrgen.sv
module dma_page_addrgen
   import dma_page_pkg::*;
#(
   parameter int unsigned PAGE_W    = 8,
   parameter int unsigned HIGH_USED = 7,
   parameter int unsigned OFS_W     = 16,
   parameter int unsigned POS_W     = 16,
   parameter bit          HIGH_EN   = 1'b1,
   localparam int unsigned PHYS_W   = HIGH_USED + PAGE_W + OFS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_en,
   input  logic              acc_wr,
   input  logic              acc_hi,
   input  logic [IDX_W-1:0]  acc_idx,
   input  logic [PAGE_W-1:0] acc_wdata,
   output logic [PAGE_W-1:0] acc_rdata,
   output logic              acc_bad,
   input  logic [CH_W-1:0]   addr_ch,
   input  logic [OFS_W-1:0]  cur_addr,
   input  logic              dir_down,
   input  logic [POS_W-1:0]  xfer_pos,
   input  logic [POS_W-1:0]  xfer_len,
   output logic [PHYS_W-1:0] phys_addr
);
   generate
      if (HIGH_USED > PAGE_W) begin : g_chk_high
         $error("HIGH_USED must not exceed PAGE_W");
      end
      if (POS_W > PHYS_W) begin : g_chk_pos
         $error("POS_W must not exceed the physical width");
      end
   endgenerate

   logic [CH_W-1:0]   sel_ch;
   logic              wr_lo, wr_hi, rd_ok, rd_dead, flag;
   logic [PAGE_W-1:0] lo_rd, hi_rd, lo_ad, hi_ad;

   dma_page_decode #(.HIGH_EN(HIGH_EN)) u_dec (
      .acc_en  (acc_en),
      .acc_wr  (acc_wr),
      .acc_hi  (acc_hi),
      .acc_idx (acc_idx),
      .sel_ch  (sel_ch),
      .wr_lo   (wr_lo),
      .wr_hi   (wr_hi),
      .rd_ok   (rd_ok),
      .rd_dead (rd_dead),
      .flag    (flag)
   );

   dma_page_bank #(.NCH(NUM_CH), .W(PAGE_W), .PRESENT(1'b1)) u_lo (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_lo),
      .wr_ch   (sel_ch),
      .wr_data (acc_wdata),
      .rd_ch   (sel_ch),
      .rd_byte (lo_rd),
      .ad_ch   (addr_ch),
      .ad_byte (lo_ad)
   );

   dma_page_bank #(.NCH(NUM_CH), .W(PAGE_W), .PRESENT(HIGH_EN)) u_hi (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_hi),
      .wr_ch   (sel_ch),
      .wr_data (acc_wdata),
      .rd_ch   (sel_ch),
      .rd_byte (hi_rd),
      .ad_ch   (addr_ch),
      .ad_byte (hi_ad)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_rdata <= '0;
         acc_bad   <= 1'b0;
      end else begin
         acc_bad <= flag;
         if (rd_ok)
            acc_rdata <= acc_hi ? hi_rd : lo_rd;
         else if (rd_dead)
            acc_rdata <= '1;
         else
            acc_rdata <= '0;
      end
   end

   dma_page_addr #(
      .PAGE_W(PAGE_W), .HIGH_USED(HIGH_USED), .OFS_W(OFS_W), .POS_W(POS_W)
   ) u_addr (
      .lo_page   (lo_ad),
      .hi_page   (hi_ad),
      .cur_addr  (cur_addr),
      .dir_down  (dir_down),
      .xfer_pos  (xfer_pos),
      .xfer_len  (xfer_len),
      .phys_addr (phys_addr)
   );
endmodule

// File: rtl/dma_page_addrgen_chk.sv
module dma_page_addrgen_chk
   import dma_page_pkg::*;
#(
   parameter int unsigned PAGE_W    = 8,
   parameter int unsigned HIGH_USED = 7,
   parameter int unsigned OFS_W     = 16,
   parameter int unsigned POS_W     = 16,
   parameter bit          HIGH_EN   = 1'b1,
   localparam int unsigned PHYS_W   = HIGH_USED + PAGE_W + OFS_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_en,
   input logic              acc_wr,
   input logic              acc_hi,
   input logic [IDX_W-1:0]  acc_idx,
   input logic [PAGE_W-1:0] acc_rdata,
   input logic              acc_bad,
   input logic [OFS_W-1:0]  cur_addr,
   input logic              dir_down,
   input logic [POS_W-1:0]  xfer_pos,
   input logic [POS_W-1:0]  xfer_len,
   input logic [PHYS_W-1:0] phys_addr
);
   logic hit;
   always_comb hit = map_port(acc_idx).hit;

   assert_mapped_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      acc_en && hit |=> !acc_bad);

   assert_unmapped_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
      acc_en && !hit && (!acc_hi || HIGH_EN) |=> acc_bad);

   assert_unmapped_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
      acc_en && !acc_wr && !hit |=> acc_rdata == '1);

   assert_up_passthru_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !dir_down && xfer_pos == '0 |-> phys_addr[OFS_W-1:0] == cur_addr);

   assert_down_passthru_R7: assert property (@(posedge clk) disable iff (!rst_n)
      dir_down && xfer_pos == '0 && xfer_len == '0 |-> phys_addr[OFS_W-1:0] == cur_addr);

   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_en |=> !acc_bad && acc_rdata == '0);

   generate
      if (!HIGH_EN) begin : g_nohigh
         assert_no_high_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
            phys_addr[PHYS_W-1 -: HIGH_USED] == '0);
         assert_high_read_ff_R8: assert property (@(posedge clk) disable iff (!rst_n)
            acc_en && !acc_wr && acc_hi |=> acc_rdata == '1 && !acc_bad);
      end
   endgenerate
endmodule

bind dma_page_addrgen dma_page_addrgen_chk #(
   .PAGE_W(PAGE_W), .HIGH_USED(HIGH_USED), .OFS_W(OFS_W), .POS_W(POS_W), .HIGH_EN(HIGH_EN)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .acc_en    (acc_en),
   .acc_wr    (acc_wr),
   .acc_hi    (acc_hi),
   .acc_idx   (acc_idx),
   .acc_rdata (acc_rdata),
   .acc_bad   (acc_bad),
   .cur_addr  (cur_addr),
   .dir_down  (dir_down),
   .xfer_pos  (xfer_pos),
   .xfer_len  (xfer_len),
   .phys_addr (phys_addr)
);

// File: tb/tb_dma_page_addrgen.sv
`timescale 1ns/1ps
module tb_dma_page_addrgen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_en = 0, acc_wr = 0, acc_hi = 0;
   logic [2:0]  acc_idx = '0;
   logic [7:0]  acc_wdata = '0;
   logic [1:0]  addr_ch = '0;
   logic [15:0] cur_addr = '0, xfer_pos = '0, xfer_len = '0;
   logic        dir_down = 0;
   logic [7:0]  rd_a, rd_b;
   logic        bad_a, bad_b;
   logic [30:0] ph_a, ph_b;

   always #2.5 clk = ~clk;

   dma_page_addrgen dut (
      .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr), .acc_hi(acc_hi),
      .acc_idx(acc_idx), .acc_wdata(acc_wdata), .acc_rdata(rd_a), .acc_bad(bad_a),
      .addr_ch(addr_ch), .cur_addr(cur_addr), .dir_down(dir_down),
      .xfer_pos(xfer_pos), .xfer_len(xfer_len), .phys_addr(ph_a));

   dma_page_addrgen #(.HIGH_EN(1'b0)) dut_nohi (
      .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr), .acc_hi(acc_hi),
      .acc_idx(acc_idx), .acc_wdata(acc_wdata), .acc_rdata(rd_b), .acc_bad(bad_b),
      .addr_ch(addr_ch), .cur_addr(cur_addr), .dir_down(dir_down),
      .xfer_pos(xfer_pos), .xfer_len(xfer_len), .phys_addr(ph_b));

   int lo_m[4], hi_m[4], lo_n[4];
   int n_chk = 0, n_bad = 0;
   bit done = 0;

   function automatic int chmap(int idx);
      case (idx)
         1: return 2;
         2: return 3;
         3: return 1;
         7: return 0;
         default: return -1;
      endcase
   endfunction

   task automatic check(string tag, string what, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   function automatic longint phys_of(int lo, int hi, int cur, bit dn, int pos, int len);
      longint b;
      b = (longint'(hi & 8'h7F) << 24) | (longint'(lo) << 16) | longint'(cur);
      b = dn ? (b - pos - len) : (b + pos);
      return b & 64'h7FFF_FFFF;
   endfunction

   task automatic op(string tag, bit en, bit wr, bit hb, int idx, int wd,
                     int ach, int cur, bit dn, int pos, int len);
      int c, ea_rd, eb_rd;
      bit ea_bad, eb_bad;
      acc_en = en; acc_wr = wr; acc_hi = hb; acc_idx = 3'(idx); acc_wdata = 8'(wd);
      addr_ch = 2'(ach); cur_addr = 16'(cur); dir_down = dn;
      xfer_pos = 16'(pos); xfer_len = 16'(len);
      @(posedge clk);
      @(negedge clk);
      c = chmap(idx);
      ea_rd = 0; eb_rd = 0; ea_bad = 0; eb_bad = 0;
      if (en) begin
         ea_bad = (c < 0);
         eb_bad = (c < 0) && !hb;
         if (!wr) begin
            ea_rd = (c < 0) ? 8'hFF : (hb ? hi_m[c] : lo_m[c]);
            eb_rd = (c < 0 || hb) ? 8'hFF : lo_n[c];
         end else if (c >= 0) begin
            if (hb) hi_m[c] = wd;
            else begin lo_m[c] = wd; lo_n[c] = wd; end
         end
      end
      check(tag, "rdata", rd_a, ea_rd);
      check(tag, "bad", bad_a, ea_bad);
      check(tag, "phys", ph_a, phys_of(lo_m[ach], hi_m[ach], cur, dn, pos, len));
      check({tag, " R8"}, "rdata(nohi)", rd_b, eb_rd);
      check({tag, " R8"}, "bad(nohi)", bad_b, eb_bad);
      check({tag, " R8"}, "phys(nohi)", ph_b, phys_of(lo_n[ach], 0, cur, dn, pos, len));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 4; i++) begin lo_m[i] = 0; hi_m[i] = 0; lo_n[i] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R9: every page reads zero after reset
      foreach (lo_m[i]) begin
         op("R9 reset low", 1, 0, 0, (i == 0) ? 7 : i, 0, 0, 16'h1234, 0, 0, 0);
         op("R9 reset high", 1, 0, 1, (i == 0) ? 7 : i, 0, 0, 16'h1234, 0, 0, 0);
      end
      // R1 R4: scrambled index order, distinct bytes per channel
      op("R1 R4 wr lo", 1, 1, 0, 7, 8'h10, 0, 0, 0, 0, 0);
      op("R1 R4 wr lo", 1, 1, 0, 3, 8'h21, 1, 0, 0, 0, 0);
      op("R1 R4 wr lo", 1, 1, 0, 1, 8'h32, 2, 0, 0, 0, 0);
      op("R1 R4 wr lo", 1, 1, 0, 2, 8'h43, 3, 0, 0, 0, 0);
      op("R1 R4 wr hi", 1, 1, 1, 7, 8'hA5, 0, 0, 0, 0, 0);
      op("R1 R4 wr hi", 1, 1, 1, 3, 8'h06, 1, 0, 0, 0, 0);
      op("R1 R4 wr hi", 1, 1, 1, 1, 8'hFF, 2, 0, 0, 0, 0);
      op("R1 R4 wr hi", 1, 1, 1, 2, 8'h7E, 3, 0, 0, 0, 0);
      for (int i = 0; i < 8; i++) begin
         op("R1 R3 R4 rd lo", 1, 0, 0, i, 0, i % 4, 16'hBEEF, 0, 0, 0);
         op("R1 R3 R4 rd hi", 1, 0, 1, i, 0, i % 4, 16'hBEEF, 0, 0, 0);
      end
      // R2: unmapped writes dropped and flagged
      foreach (lo_m[i]) begin
         op("R2 wr unmapped", 1, 1, i[0], (i == 0) ? 0 : i + 3, 8'hCC, i, 16'h0F0F, 0, 0, 0);
      end
      for (int i = 0; i < 4; i++) op("R2 R4 readback", 1, 0, 0, chmap(i) < 0 ? 7 : i, 0, i, 0, 0, 0, 0);
      // R10: idle cycle and write leave quiet outputs
      op("R10 idle", 0, 0, 0, 0, 0, 2, 16'h0001, 0, 0, 0);
      op("R10 idle unmapped idx", 0, 1, 1, 4, 8'h99, 2, 16'h0001, 0, 0, 0);
      // R5 R6: addressing up, bit 7 of high page masked
      op("R5 R6 up", 0, 0, 0, 0, 0, 2, 16'h8000, 0, 16'h0100, 0);
      op("R5 R6 up carry", 0, 0, 0, 0, 0, 0, 16'hFFFF, 0, 16'h0001, 16'h5555);
      op("R5 R6 up wrap", 0, 0, 0, 0, 0, 2, 16'hFFF0, 0, 16'hFFFF, 0);
      // R7: addressing down, including borrow past the page
      op("R7 down", 0, 0, 0, 0, 0, 1, 16'h1000, 1, 16'h0010, 16'h0020);
      op("R7 down borrow", 0, 0, 0, 0, 0, 3, 16'h0005, 1, 16'h0004, 16'h0008);
      op("R7 down zero", 0, 0, 0, 0, 0, 0, 16'h00FF, 1, 0, 0);
      // R4: overwrite then read in consecutive cycles
      op("R4 rewrite", 1, 1, 0, 3, 8'h00, 1, 16'h2222, 1, 1, 1);
      op("R4 rewrite rd", 1, 0, 0, 3, 0, 1, 16'h2222, 1, 1, 1);
      op("R4 R10 settle", 0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
      // R9: reset again clears all pages
      rst_n = 1'b0;
      @(posedge clk); @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 4; i++) begin lo_m[i] = 0; hi_m[i] = 0; lo_n[i] = 0; end
      op("R9 rereset", 1, 0, 1, 1, 0, 2, 16'h4444, 0, 0, 0);
      op("R9 rereset", 1, 0, 0, 2, 0, 3, 16'h4444, 1, 2, 2);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule